// File: doc/BRIEF.md
# PLL Divider Reconfiguration Sequencer

This block owns the control pins of a fractional-capable PLL and changes its frequency on command. A caller presents a request with a main divider M, a pre-divider P, a post-divider S and a 16-bit fraction K. The block compares the new M and P with the values already on its outputs. When they match, only S (and K for the fractional build) is rewritten, and the PLL keeps running without a relock. When either one differs, the block runs a fixed relock sequence: reset low, bypass on, dividers loaded, a reset hold time, reset release, a wait for lock bounded by a timeout, and then bypass off.

The same command port also takes power-up and power-down requests. A power-up turns the PLL on through bypass and lock. A power-down only pulls its reset low. The hold time and the lock timeout are given in nanoseconds and are turned into core-clock cycles from the clock frequency parameter. The lock input is asynchronous and passes through two flops before the sequencer uses it. While a sequence is in progress the port is not ready. Every accepted request ends with exactly one cycle of done or of error.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, pll_rst_n, pll_bypass and pll_lock_src are 0, all divider outputs are 0, req_ready is 1, and done and error are 0.
- R2: A set request (req_op 0) whose M and P equal the current pll_main and pll_pre updates pll_post, and pll_frac in the fractional build, at the accepting edge. pll_rst_n and pll_bypass do not change, and done is high in the cycle right after acceptance.
- R3: A set request with a different M or P drives pll_rst_n low 1 cycle after acceptance, raises pll_bypass 2 cycles after acceptance, and loads all dividers 3 cycles after acceptance.
- R4: After the dividers are loaded, pll_rst_n stays low for HOLD_CYC = ceil(CLK_FREQ_HZ*HOLD_NS/1e9) cycles and then goes high.
- R5: pll_lock is synchronised by two flops. pll_bypass clears, and done rises, 3 cycles after pll_lock goes high while the block is waiting for lock.
- R6: If no lock arrives within LOCK_CYC = ceil(CLK_FREQ_HZ*LOCK_NS/1e9) cycles after reset release, error pulses exactly LOCK_CYC cycles after the release. pll_bypass and pll_rst_n are both left at 1.
- R7: With FRAC=0, pll_lock_src is set at the start of a relock and stays 1, and pll_frac stays 0 whatever K is requested. With FRAC=1, pll_lock_src stays 0.
- R8: An enable request (req_op 1) when pll_rst_n is 0 raises pll_bypass at acceptance and releases reset one cycle later. It then waits for lock as in R5. When pll_rst_n is already 1, the request completes in the cycle after acceptance and changes nothing.
- R9: A disable request (req_op 2) drives pll_rst_n low at acceptance, leaves the dividers as they are, and raises done in the cycle right after acceptance.
- R10: req_ready is low from acceptance until the done or error cycle has passed. Requests presented while it is low are ignored.
- R11: The reserved request code 3 completes with done in the cycle after acceptance and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 set dividers, 1 enable, 2 disable, 3 reserved |
| req_m | input | 10 | Requested main divider |
| req_p | input | 6 | Requested pre-divider |
| req_s | input | 3 | Requested post-divider |
| req_k | input | 16 | Requested fraction |
| req_ready | output | 1 | Idle, a request is taken on this edge |
| pll_main | output | 10 | Main divider to the PLL |
| pll_pre | output | 6 | Pre-divider to the PLL |
| pll_post | output | 3 | Post-divider to the PLL |
| pll_frac | output | 16 | Fraction to the PLL |
| pll_rst_n | output | 1 | PLL reset, low holds it in power-down |
| pll_bypass | output | 1 | Route the reference clock around the PLL |
| pll_lock_src | output | 1 | Use the PLL output lock as lock source |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| done | output | 1 | One-cycle pulse when a request completes |
| error | output | 1 | One-cycle pulse on lock timeout |

## Verification
A sequencer whose state has gone wrong shows it at the ports within a few cycles of acceptance. A fast-path decision taken in error leaves bypass untouched and raises done in the cycle after acceptance, when a relock was expected. A skipped or reordered step moves the first edge of reset or bypass away from its fixed offset. A wrong hold or timeout count moves the reset release or the error pulse by a known number of cycles. The bench timestamps each output transition against the accepting edge, so an error of a single cycle in any step is caught in the request where it happens.

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned HOLD_NS     = 3000,
  parameter int unsigned LOCK_NS     = 10_000_000,
  parameter bit          FRAC        = 1'b1,
  parameter int          M_W         = 10,
  parameter int          P_W         = 6,
  parameter int          S_W         = 3,
  parameter int          K_W         = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_op,
  input  logic [M_W-1:0] req_m,
  input  logic [P_W-1:0] req_p,
  input  logic [S_W-1:0] req_s,
  input  logic [K_W-1:0] req_k,
  output logic           req_ready,
  output logic [M_W-1:0] pll_main,
  output logic [P_W-1:0] pll_pre,
  output logic [S_W-1:0] pll_post,
  output logic [K_W-1:0] pll_frac,
  output logic           pll_rst_n,
  output logic           pll_bypass,
  output logic           pll_lock_src,
  input  logic           pll_lock,
  output logic           done,
  output logic           error
);
  localparam longint HOLD_L   = (longint'(CLK_FREQ_HZ) * longint'(HOLD_NS) + 999_999_999) / 1_000_000_000;
  localparam longint LOCK_L   = (longint'(CLK_FREQ_HZ) * longint'(LOCK_NS) + 999_999_999) / 1_000_000_000;
  localparam int     HOLD_CYC = (HOLD_L < 1) ? 1 : int'(HOLD_L);
  localparam int     LOCK_CYC = (LOCK_L < 1) ? 1 : int'(LOCK_L);
  localparam int     CNT_MAX  = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int     CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [1:0] OP_SET = 2'd0, OP_EN = 2'd1, OP_DIS = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_BYP, S_LOAD, S_HOLD, S_REL, S_LOCK, S_FIN, S_ERR
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [M_W-1:0]   n_m;
  logic [P_W-1:0]   n_p;
  logic [S_W-1:0]   n_s;
  logic [K_W-1:0]   n_k;
  logic             lk1, lk2;

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign error     = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      n_m <= '0; n_p <= '0; n_s <= '0; n_k <= '0;
      pll_main <= '0; pll_pre <= '0; pll_post <= '0; pll_frac <= '0;
      pll_rst_n <= 1'b0;
      pll_bypass <= 1'b0;
      pll_lock_src <= 1'b0;
      lk1 <= 1'b0;
      lk2 <= 1'b0;
    end else begin
      lk1 <= pll_lock;
      lk2 <= lk1;
      case (st)
        S_IDLE: if (req_valid) begin
          case (req_op)
            OP_SET: begin
              if (req_m == pll_main && req_p == pll_pre) begin
                pll_post <= req_s;
                if (FRAC) pll_frac <= req_k;
                st <= S_FIN;
              end else begin
                n_m <= req_m; n_p <= req_p; n_s <= req_s; n_k <= req_k;
                if (!FRAC) pll_lock_src <= 1'b1;
                st <= S_RST;
              end
            end
            OP_EN: begin
              if (pll_rst_n) st <= S_FIN;
              else begin
                pll_bypass <= 1'b1;
                st <= S_REL;
              end
            end
            OP_DIS: begin
              pll_rst_n <= 1'b0;
              st <= S_FIN;
            end
            default: st <= S_FIN;
          endcase
        end
        S_RST: begin
          pll_rst_n <= 1'b0;
          st <= S_BYP;
        end
        S_BYP: begin
          pll_bypass <= 1'b1;
          st <= S_LOAD;
        end
        S_LOAD: begin
          pll_main <= n_m; pll_pre <= n_p; pll_post <= n_s;
          if (FRAC) pll_frac <= n_k;
          cnt <= '0;
          st <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            pll_rst_n <= 1'b1;
            cnt <= '0;
            st <= S_LOCK;
          end else cnt <= cnt + 1'b1;
        end
        S_REL: begin
          pll_rst_n <= 1'b1;
          cnt <= '0;
          st <= S_LOCK;
        end
        S_LOCK: begin
          if (lk2) begin
            pll_bypass <= 1'b0;
            st <= S_FIN;
          end else if (cnt == CNT_W'(LOCK_CYC - 1)) st <= S_ERR;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RELEASE_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_n) |-> pll_bypass); // R3

  AST_DIV_LOAD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pll_main) || !$stable(pll_pre)) |-> !pll_rst_n); // R2

  AST_UNBYPASS_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> $past(lk2)); // R5

  AST_ERR_LEAVES_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (pll_bypass && pll_rst_n)); // R6

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R10

  AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> req_ready); // R10

  AST_INT_NO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    !FRAC |-> (pll_frac == '0)); // R7
endmodule

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;
  localparam int HOLD_EXP = 750;    // ceil(250e6 * 3000 / 1e9)
  localparam int LOCK_EXP = 10000;  // ceil(250e6 * 40000 / 1e9)
  localparam int LOCK_DLY = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [9:0] req_m = '0;
  logic [5:0] req_p = '0;
  logic [2:0] req_s = '0;
  logic [15:0] req_k = '0;

  logic rdy0, rb0, byp0, ls0, dn0, er0;
  logic [9:0] m0; logic [5:0] p0; logic [2:0] s0; logic [15:0] k0;
  logic rdy1, rb1, byp1, ls1, dn1, er1;
  logic [9:0] m1; logic [5:0] p1; logic [2:0] s1; logic [15:0] k1;
  logic lock0 = 1'b0, lock1 = 1'b0;
  bit no_lock = 1'b0;
  int lc0 = 0, lc1 = 0;

  pll_reprog_seq #(.CLK_FREQ_HZ(250_000_000), .HOLD_NS(3000), .LOCK_NS(40000), .FRAC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_m(req_m), .req_p(req_p),
    .req_s(req_s), .req_k(req_k), .req_ready(rdy0), .pll_main(m0), .pll_pre(p0), .pll_post(s0),
    .pll_frac(k0), .pll_rst_n(rb0), .pll_bypass(byp0), .pll_lock_src(ls0), .pll_lock(lock0),
    .done(dn0), .error(er0));

  pll_reprog_seq #(.CLK_FREQ_HZ(250_000_000), .HOLD_NS(3000), .LOCK_NS(40000), .FRAC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_m(req_m), .req_p(req_p),
    .req_s(req_s), .req_k(req_k), .req_ready(rdy1), .pll_main(m1), .pll_pre(p1), .pll_post(s1),
    .pll_frac(k1), .pll_rst_n(rb1), .pll_bypass(byp1), .pll_lock_src(ls1), .pll_lock(lock1),
    .done(dn1), .error(er1));

  always @(negedge clk) begin
    if (!rb0) begin lc0 = 0; lock0 = 1'b0; end
    else if (no_lock) lock0 = 1'b0;
    else if (lc0 == LOCK_DLY) lock0 = 1'b1;
    else lc0++;
    if (!rb1) begin lc1 = 0; lock1 = 1'b0; end
    else if (no_lock) lock1 = 1'b0;
    else if (lc1 == LOCK_DLY) lock1 = 1'b1;
    else lc1++;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int c_acc, c_rstlo, c_byp, c_load, c_rsthi, c_end;
  bit saw_byp, got_err;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic run_req(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                         input logic [2:0] s, input logic [15:0] k);
    logic [9:0] om; logic [5:0] op_old; logic prev_rb, last_rb;
    om = m0; op_old = p0; prev_rb = rb0; last_rb = rb0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_m = m; req_p = p; req_s = s; req_k = k;
    @(posedge clk);
    #1 c_acc = cyc;
    c_rstlo = -1; c_byp = -1; c_load = -1; c_rsthi = -1; c_end = -1;
    saw_byp = 1'b0; got_err = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (!rb0 && prev_rb && c_rstlo < 0) c_rstlo = cyc;
      if (byp0 && c_byp < 0) begin c_byp = cyc; saw_byp = 1'b1; end
      if ((m0 != om || p0 != op_old) && c_load < 0) c_load = cyc;
      if (rb0 && !last_rb && c_rsthi < 0) c_rsthi = cyc;
      last_rb = rb0;
      if (dn0 || er0) begin c_end = cyc; got_err = er0; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  localparam logic [37:0] VEC [9] = '{
    {2'd0, 10'd225, 6'd3, 3'd0, 16'd0,     1'b1},
    {2'd0, 10'd225, 6'd3, 3'd1, 16'd0,     1'b0},
    {2'd0, 10'd262, 6'd2, 3'd3, 16'd9437,  1'b1},
    {2'd0, 10'd262, 6'd2, 3'd3, 16'd17511, 1'b0},
    {2'd2, 10'd0,   6'd0, 3'd0, 16'd0,     1'b0},
    {2'd1, 10'd0,   6'd0, 3'd0, 16'd0,     1'b1},
    {2'd1, 10'd0,   6'd0, 3'd0, 16'd0,     1'b0},
    {2'd3, 10'd77,  6'd9, 3'd5, 16'd5,     1'b0},
    {2'd0, 10'd300, 6'd3, 3'd2, 16'd0,     1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [9:0] em; logic [5:0] ep; logic [2:0] es; logic [15:0] ek; logic erb;
    em = '0; ep = '0; es = '0; ek = '0; erb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rst_n", rb0, 0);
    chk("R1 bypass", byp0, 0);
    chk("R1 lock_src", ls0 | ls1, 0);
    chk("R1 dividers", {m0, p0, s0, k0}, 0);
    chk("R1 ready", rdy0, 1);
    chk("R1 done/error", {dn0, er0}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      logic [1:0] op; logic [9:0] m; logic [5:0] p; logic [2:0] s; logic [15:0] k;
      logic rl, prev_rb;
      {op, m, p, s, k, rl} = VEC[i];
      prev_rb = rb0;
      run_req(op, m, p, s, k);
      case (op)
        2'd0: begin
          if (rl) begin em = m; ep = p; es = s; ek = k; erb = 1'b1; end
          else begin es = s; ek = k; end
        end
        2'd1: erb = 1'b1;
        2'd2: erb = 1'b0;
        default: ;
      endcase
      chk($sformatf("R2 R3 vec%0d dividers", i), {m0, p0, s0, k0}, {em, ep, es, ek});
      chk($sformatf("R8 R9 vec%0d rst_n", i), rb0, erb);
      chk($sformatf("R5 vec%0d bypass cleared", i), byp0, 0);
      chk($sformatf("R10 vec%0d no error, ready", i), {got_err, rdy0}, 2'b01);
      chk($sformatf("R2 vec%0d relock seen", i), saw_byp, rl);
      if (op == 2'd0 && rl && prev_rb) begin
        chk($sformatf("R3 vec%0d reset low offset", i), c_rstlo - c_acc, 1);
        chk($sformatf("R3 vec%0d bypass offset", i), c_byp - c_acc, 2);
        chk($sformatf("R3 vec%0d load offset", i), c_load - c_acc, 3);
        chk($sformatf("R4 vec%0d hold cycles", i), c_rsthi - c_load, HOLD_EXP);
        chk($sformatf("R5 vec%0d lock to done", i), c_end - c_rsthi, LOCK_DLY + 3);
      end
      if (op == 2'd0 && !rl) chk($sformatf("R2 vec%0d immediate done", i), c_end - c_acc, 0);
      if (op == 2'd1 && rl) begin
        chk($sformatf("R8 vec%0d bypass at accept", i), c_byp - c_acc, 0);
        chk($sformatf("R8 vec%0d release offset", i), c_rsthi - c_acc, 1);
        chk($sformatf("R8 vec%0d lock to done", i), c_end - c_rsthi, LOCK_DLY + 3);
      end
      if (op == 2'd1 && !rl) chk($sformatf("R8 vec%0d noop done", i), c_end - c_acc, 0);
      if (op == 2'd2) chk($sformatf("R9 vec%0d done", i), c_end - c_acc, 0);
      if (op == 2'd3) chk($sformatf("R11 vec%0d done", i), c_end - c_acc, 0);
      if (i == 2) begin
        chk("R7 integer lock_src set", ls1, 1);
        chk("R7 integer frac held", k1, 0);
        chk("R7 fractional lock_src clear", ls0, 0);
        chk("R7 integer main loaded", m1, 262);
      end
    end

    // R10: requests while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_m = 10'd350; req_p = 6'd3; req_s = 3'd1; req_k = '0;
    @(negedge clk);
    chk("R10 ready low when busy", rdy0, 0);
    req_op = 2'd2;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (dn0 || er0) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R10 disable while busy ignored", rb0, 1);
    chk("R10 busy request result", m0, 350);
    repeat (10) @(negedge clk);
    chk("R10 still idle and on", {rdy0, rb0, byp0}, 3'b110);

    // R6: lock timeout
    no_lock = 1'b1;
    run_req(2'd0, 10'd250, 6'd3, 3'd1, 16'd0);
    chk("R6 error pulse", got_err, 1);
    chk("R6 timeout cycles", c_end - c_rsthi, LOCK_EXP);
    chk("R6 bypass left on", byp0, 1);
    chk("R6 reset left released", rb0, 1);
    no_lock = 1'b0;
    run_req(2'd0, 10'd200, 6'd3, 3'd0, 16'd0);
    chk("R6 recovery relock", {got_err, byp0, rb0}, 3'b001);
    chk("R6 recovery dividers", {m0, p0}, {10'd200, 6'd3});

    summary();
    $finish;
  end
endmodule